// File: doc/BRIEF.md
# Boot Isolation Level Controller

This block tracks a one-way boot isolation level for a secure boot chain. Every boot stage can raise the level by one step before it hands over to the next stage. No command lowers the level. Only a reset brings it back to the lowest level. The level is never held as a small binary count. It is held as one of four sparse 8-bit codes, so a single upset bit cannot turn it into another legal level.

The same block decides whether debug may open. The access port opens when a key byte is written. Debug opens only when an unlock key is written while the current level equals a preset authorisation level. A secure-debug key byte decides whether secure debug opens as well as non-secure debug. A lock byte can freeze all of these debug fields. Its read-back hides any stored value except the one that leaves the fields open.

A 2-bit next-level index is added to the current level number to form a pointer to the storage area of a later stage. All fields sit behind one byte-wide write port and one combinational read port, and each field has its own 3-bit address.

Top module: `boot_level_ctrl`

## Requirements
- R1: After reset the state is as follows. The level code is 0xB4 (level 0). The access-port flag and both debug flags are 0. The pointer is 0. The lock field reads 0xB4. The authorisation field (address 5) and the secure-key field (address 6) read 0x00.
- R2: Writing a byte other than 0xB4 to the step field (address 0) moves the level one step along the sequence 0xB4, 0x51, 0x8A, 0x6F. The new code appears on `level_code`, and on reads of address 1, after the next clock edge.
- R3: Writing 0xB4 to the step field leaves the level unchanged. A step write at level 3 (0x6F) leaves the level at level 3.
- R4: The level number never decreases between two clock edges unless reset is applied.
- R5: The authorisation field (address 5) stores a written byte only if the byte is 0x51, 0x8A or 0x6F. Any other byte is ignored. Reads of address 5 return the stored byte.
- R6: The non-secure debug flag sets when 0xB4 is written to the unlock field (address 4) and, at that write, the level code equals the authorisation field. Any other value written, or a level that does not match, leaves the flag unchanged. Reads of address 4 return {6'b0, secure flag, non-secure flag}.
- R7: When debug opens, the secure flag sets as well if the secure-key field (address 6) holds 0xB4 at that write. Otherwise only the non-secure flag sets. The secure flag is never 1 while the non-secure flag is 0.
- R8: Writing 0xB4 to the access-port key field (address 3) sets the access-port flag. Other bytes leave the flag unchanged. Reads of address 3 return {7'b0, flag}.
- R9: While the stored lock byte (address 7) is not 0xB4, writes to addresses 3, 4, 5 and 6 are ignored. The lock field itself stays writable at all times.
- R10: Reading address 7 returns 0xB4 when the stored lock byte is 0xB4, and returns 0x6A for any other stored byte.
- R11: The pointer equals the level number (0 to 3) plus the next-level index. The index is held in bits [1:0] of address 2 and reads back as {6'b0, index}. The pointer is 3 bits wide and reaches 6 at most.
- R12: Once set, the access-port flag and the debug flags stay set until reset, whatever is written afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one byte field |
| wr_addr | input | 3 | Field address of the write |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 3 | Field address of the read |
| rd_data | output | 8 | Read byte (combinational) |
| level_code | output | 8 | Current level code |
| ap_open | output | 1 | Access port open |
| dbg_ns_open | output | 1 | Non-secure debug open |
| dbg_s_open | output | 1 | Secure debug open |
| area_ptr | output | 3 | Storage-area level pointer |

## Verification
A wrong level code shows on `level_code` one cycle after the step write that caused it. The same error also shows later as a debug open that should not happen, or one that is missing, because debug opening compares the level code with the authorisation byte. A lock that fails to block writes shows on the next read of address 3 to 6. A wrong read-back mask shows on the very next read of address 7. The bench runs a model computed from the requirements beside the design. After every write it compares all outputs and all eight read addresses, so any divergence is reported in the cycle it first appears.

// File: rtl/blc_pkg.sv
package blc_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;
    localparam int IDX_W  = 2;

    localparam logic [BYTE_W-1:0] LVL0_CODE   = 8'hB4;
    localparam logic [BYTE_W-1:0] LVL1_CODE   = 8'h51;
    localparam logic [BYTE_W-1:0] LVL2_CODE   = 8'h8A;
    localparam logic [BYTE_W-1:0] LVL3_CODE   = 8'h6F;
    localparam logic [BYTE_W-1:0] OPEN_KEY    = 8'hB4;
    localparam logic [BYTE_W-1:0] STEP_HOLD   = 8'hB4;
    localparam logic [BYTE_W-1:0] LOCK_MASKED = 8'h6A;

    typedef enum logic [ADDR_W-1:0] {
        FLD_STEP   = 3'd0,
        FLD_LEVEL  = 3'd1,
        FLD_NEXT   = 3'd2,
        FLD_APKEY  = 3'd3,
        FLD_DBGKEY = 3'd4,
        FLD_AUTH   = 3'd5,
        FLD_SECKEY = 3'd6,
        FLD_LOCK   = 3'd7
    } fld_e;

    function automatic logic [IDX_W-1:0] lvl_index(input logic [BYTE_W-1:0] code);
        case (code)
            LVL0_CODE: return 2'd0;
            LVL1_CODE: return 2'd1;
            LVL2_CODE: return 2'd2;
            default:   return 2'd3;
        endcase
    endfunction

    function automatic logic auth_ok(input logic [BYTE_W-1:0] b);
        return (b == LVL1_CODE) || (b == LVL2_CODE) || (b == LVL3_CODE);
    endfunction
endpackage

// File: rtl/blc_level_reg.sv
module blc_level_reg
    import blc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_we,
    input  logic [BYTE_W-1:0] step_data,
    output logic [BYTE_W-1:0] level_code,
    output logic [IDX_W-1:0]  level_idx
);
    typedef struct packed {
        logic [BYTE_W-1:0] code;
    } lvl_st_t;

    lvl_st_t lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (step_we && (step_data != STEP_HOLD)) begin
            case (lvl_q.code)
                LVL0_CODE: lvl_d.code = LVL1_CODE;
                LVL1_CODE: lvl_d.code = LVL2_CODE;
                LVL2_CODE: lvl_d.code = LVL3_CODE;
                default:   lvl_d.code = LVL3_CODE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '{code: LVL0_CODE};
        else        lvl_q <= lvl_d;
    end

    assign level_code = lvl_q.code;
    assign level_idx  = lvl_index(lvl_q.code);

    // R2: the stored code is always one of the four legal codes
    assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q.code == LVL0_CODE) || (lvl_q.code == LVL1_CODE) ||
        (lvl_q.code == LVL2_CODE) || (lvl_q.code == LVL3_CODE));

    // R4: the level only moves upward
    assert_no_downstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_index(lvl_q.code) >= $past(lvl_index(lvl_q.code)));

    // R3: a hold write changes nothing
    assert_hold_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_we && step_data == STEP_HOLD) |=> $stable(lvl_q.code));
endmodule

// File: rtl/blc_dbg_gate.sv
module blc_dbg_gate
    import blc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] level_code,
    output logic [BYTE_W-1:0] auth_byte,
    output logic [BYTE_W-1:0] sec_byte,
    output logic [BYTE_W-1:0] lock_view,
    output logic              ap_open,
    output logic              dbg_ns_open,
    output logic              dbg_s_open
);
    typedef struct packed {
        logic [BYTE_W-1:0] lock;
        logic [BYTE_W-1:0] auth;
        logic [BYTE_W-1:0] sec;
        logic              ap;
        logic              ns;
        logic              s;
    } gate_st_t;

    localparam gate_st_t GATE_RST = '{lock: OPEN_KEY, auth: '0, sec: '0,
                                      ap: 1'b0, ns: 1'b0, s: 1'b0};

    gate_st_t g_d, g_q;
    logic     cfg_open;

    assign cfg_open = (g_q.lock == OPEN_KEY);

    always_comb begin
        g_d = g_q;
        if (wr_en) begin
            if (wr_addr == FLD_LOCK) g_d.lock = wr_data;
            if (cfg_open) begin
                case (wr_addr)
                    FLD_APKEY:  if (wr_data == OPEN_KEY) g_d.ap = 1'b1;
                    FLD_AUTH:   if (auth_ok(wr_data)) g_d.auth = wr_data;
                    FLD_SECKEY: g_d.sec = wr_data;
                    FLD_DBGKEY: begin
                        if ((wr_data == OPEN_KEY) && auth_ok(g_q.auth) &&
                            (level_code == g_q.auth)) begin
                            g_d.ns = 1'b1;
                            if (g_q.sec == OPEN_KEY) g_d.s = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= GATE_RST;
        else        g_q <= g_d;
    end

    assign auth_byte   = g_q.auth;
    assign sec_byte    = g_q.sec;
    assign lock_view   = cfg_open ? OPEN_KEY : LOCK_MASKED;
    assign ap_open     = g_q.ap;
    assign dbg_ns_open = g_q.ns;
    assign dbg_s_open  = g_q.s;

    // R7: secure debug never open without non-secure debug
    assert_s_implies_ns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.s |-> g_q.ns);

    // R12: flags are sticky
    assert_ap_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.ap |=> g_q.ap);
    assert_ns_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.ns |=> g_q.ns);

    // R6: debug opens only on a level match with the stored authorisation
    assert_open_on_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.ns) |-> ($past(level_code) == $past(g_q.auth)));

    // R9: a locked block keeps its debug fields frozen
    assert_locked_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(g_q.auth) && $stable(g_q.sec) && $stable(g_q.ap)));

    // R5: the authorisation byte is zero or a legal code
    assert_auth_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.auth == '0) || auth_ok(g_q.auth));
endmodule

// File: rtl/boot_level_ctrl.sv
module boot_level_ctrl
    import blc_pkg::*;
#(
    parameter int PTR_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] level_code,
    output logic              ap_open,
    output logic              dbg_ns_open,
    output logic              dbg_s_open,
    output logic [PTR_W-1:0]  area_ptr
);
    typedef struct packed {
        logic [IDX_W-1:0] next;
    } top_st_t;

    top_st_t           t_d, t_q;
    logic [IDX_W-1:0]  level_idx;
    logic [BYTE_W-1:0] auth_byte, sec_byte, lock_view;

    blc_level_reg u_level (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_we    (wr_en && (wr_addr == FLD_STEP)),
        .step_data  (wr_data),
        .level_code (level_code),
        .level_idx  (level_idx)
    );

    blc_dbg_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .level_code  (level_code),
        .auth_byte   (auth_byte),
        .sec_byte    (sec_byte),
        .lock_view   (lock_view),
        .ap_open     (ap_open),
        .dbg_ns_open (dbg_ns_open),
        .dbg_s_open  (dbg_s_open)
    );

    always_comb begin
        t_d = t_q;
        if (wr_en && (wr_addr == FLD_NEXT)) t_d.next = wr_data[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{next: '0};
        else        t_q <= t_d;
    end

    assign area_ptr = PTR_W'(level_idx) + PTR_W'(t_q.next);

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            FLD_LEVEL:  rd_data = level_code;
            FLD_NEXT:   rd_data = BYTE_W'(t_q.next);
            FLD_APKEY:  rd_data = BYTE_W'(ap_open);
            FLD_DBGKEY: rd_data = BYTE_W'({dbg_s_open, dbg_ns_open});
            FLD_AUTH:   rd_data = auth_byte;
            FLD_SECKEY: rd_data = sec_byte;
            FLD_LOCK:   rd_data = lock_view;
            default:    rd_data = '0;
        endcase
    end

    // R11: the pointer never falls below the current level number
    assert_ptr_floor_R11: assert property (@(posedge clk) disable iff (!rst_n)
        area_ptr >= PTR_W'(level_idx));
endmodule

// File: tb/boot_level_ctrl_test.sv
`timescale 1ns/100ps
module boot_level_ctrl_test;
    localparam real CLK_PERIOD = 10.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data, level_code;
    logic       ap_open, dbg_ns_open, dbg_s_open;
    logic [2:0] area_ptr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int         m_lvl, m_next;
    logic [7:0] m_auth, m_sec, m_lock;
    bit         m_ap, m_ns, m_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_level_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .level_code(level_code), .ap_open(ap_open), .dbg_ns_open(dbg_ns_open),
        .dbg_s_open(dbg_s_open), .area_ptr(area_ptr)
    );

    function automatic logic [7:0] code_of(input int i);
        case (i)
            0: return 8'hB4;
            1: return 8'h51;
            2: return 8'h8A;
            default: return 8'h6F;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input int a);
        case (a)
            1: return code_of(m_lvl);
            2: return 8'(m_next);
            3: return {7'b0, m_ap};
            4: return {6'b0, m_s, m_ns};
            5: return m_auth;
            6: return m_sec;
            7: return (m_lock == 8'hB4) ? 8'hB4 : 8'h6A;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lvl = 0; m_next = 0; m_auth = 8'h00; m_sec = 8'h00; m_lock = 8'hB4;
        m_ap = 0; m_ns = 0; m_s = 0;
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        bit open_cfg;
        open_cfg = (m_lock == 8'hB4);
        case (a)
            0: if (d != 8'hB4 && m_lvl < 3) m_lvl++;
            2: m_next = int'(d[1:0]);
            3: if (open_cfg && d == 8'hB4) m_ap = 1;
            4: if (open_cfg && d == 8'hB4 && code_of(m_lvl) == m_auth) begin
                   m_ns = 1;
                   if (m_sec == 8'hB4) m_s = 1;
               end
            5: if (open_cfg && (d == 8'h51 || d == 8'h8A || d == 8'h6F)) m_auth = d;
            6: if (open_cfg) m_sec = d;
            7: m_lock = d;
            default: ;
        endcase
    endtask

    task automatic check_all();
        chk("R2 level_code", level_code, code_of(m_lvl));
        chk("R8 ap_open", ap_open, m_ap);
        chk("R6 dbg_ns_open", dbg_ns_open, m_ns);
        chk("R7 dbg_s_open", dbg_s_open, m_s);
        chk("R11 area_ptr", area_ptr, m_lvl + m_next);
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #0.2;
            chk(a == 7 ? "R10 read lock" : a == 5 ? "R5 read auth" : "R12 read field",
                rd_data, exp_rd(a));
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        check_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check_all();
    endtask

    function automatic logic [7:0] pick(input int unsigned r, input int unsigned raw);
        case (r % 8)
            0: return 8'hB4;
            1: return 8'h6A;
            2: return 8'h51;
            3: return 8'h8A;
            4: return 8'h6F;
            5: return 8'hC3;
            6: return 8'(raw);
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int prev;
        seed = 32'd1234;
        void'($urandom(seed));
        model_reset();
        do_reset();
        chk("R1 reset level", level_code, 8'hB4);
        chk("R1 reset ptr", area_ptr, 0);

        wr(0, 8'hB4);
        chk("R3 hold step", level_code, 8'hB4);
        wr(5, 8'h22);
        chk("R5 illegal auth ignored", exp_rd(5), 8'h00);
        wr(5, 8'h51);
        wr(4, 8'hB4);
        chk("R6 mismatch no open", dbg_ns_open, 0);
        wr(0, 8'h6A);
        wr(4, 8'h00);
        chk("R6 wrong key no open", dbg_ns_open, 0);
        wr(4, 8'hB4);
        chk("R7 ns only", {dbg_s_open, dbg_ns_open}, 2'b01);
        wr(0, 8'h01); wr(0, 8'h6A); wr(0, 8'hFF);
        chk("R3 saturate at top", level_code, 8'h6F);

        wr(7, 8'hC3);
        chk("R10 masked lock", (rd_addr == 7) ? rd_data : 8'h00, 8'h6A);
        wr(5, 8'h8A);
        wr(3, 8'hB4);
        chk("R9 locked ap ignored", ap_open, 0);
        wr(7, 8'hB4);
        wr(3, 8'h11);
        chk("R8 wrong ap key", ap_open, 0);
        wr(3, 8'hB4);
        chk("R8 ap opens", ap_open, 1);

        do_reset();
        wr(6, 8'hB4); wr(5, 8'h6F);
        wr(0, 8'h6A); wr(0, 8'h6A); wr(0, 8'h6A);
        wr(4, 8'hB4);
        chk("R7 both open", {dbg_s_open, dbg_ns_open}, 2'b11);
        wr(6, 8'h00); wr(5, 8'h51);
        chk("R12 flags hold", dbg_s_open, 1);
        wr(2, 8'hFF);
        chk("R11 pointer max", area_ptr, 6);

        do_reset();
        prev = 0;
        for (int i = 0; i < 600; i++) begin
            int unsigned ra, rd;
            ra = $urandom % 8;
            rd = $urandom;
            if (i % 150 == 149) begin
                do_reset();
                prev = 0;
            end
            wr(int'(ra), pick($urandom, rd));
            chk("R4 no downstep", (m_lvl >= prev), 1);
            prev = m_lvl;
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule